// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block decodes a card-to-reader response that carries no start marker, stop marker or length field. Once the controller pulses `start_i` at the end of its own outgoing frame, the block waits a fixed guard interval. It then divides time into back-to-back bit windows of fixed length. In each window it counts level changes on the comparator output, after that output has passed through a synchroniser. A card that answers with a 1 modulates a subcarrier, which produces a burst of transitions. A 0 leaves the line quiet. The edge count in each window therefore selects the bit value.

The expected bit count and a keystream word are captured when the start pulse is accepted. Decoded bits are packed least significant bit first into a word, and that word is XORed with the captured keystream. The result is presented with a single-cycle valid strobe. Both the guard interval and the window length are parameters given in clock cycles. With the defaults at 24 MHz they correspond to roughly 330 us and 100 us.

Top module: `subcar_demod`

## Requirements
- R1: After reset `valid_o` is 0 and `data_o` is all zeros.
- R2: With N the effective bit count, `valid_o` rises exactly WAIT_CYC + N*WIN_CYC clock cycles after the cycle in which `start_i` was accepted, and it stays high for exactly one cycle.
- R3: A window whose synchronised edge count is strictly greater than ONE_LO (20) and strictly less than ONE_HI (60) decodes as a 1. For example, 21, 42 and 59 edges each give a 1.
- R4: A window whose edge count is ONE_LO or less, or ONE_HI or more, decodes as 0. For example, 0, 20 and 60 edges each give a 0.
- R5: The per-window edge counter saturates at its maximum (2^CNT_W - 1) and never wraps. A window with more edges than that decodes as 0.
- R6: The bit from window k (the first window is k = 0) is placed at bit position k of the result, so the first received bit lands in bit 0.
- R7: `data_o` equals the keystream captured at start XOR the received bits. Bit positions at or above N carry the keystream bits unchanged.
- R8: A requested bit count above 32 is clamped to 32.
- R9: While a reception is in progress, `start_i`, `key_i` and `nbits_i` are ignored, and neither the result nor its timing changes.
- R10: A bit count of 0 produces the strobe right after the guard interval, with `data_o` equal to the captured keystream.
- R11: `data_o` changes only in the cycle in which `valid_o` is high, and it holds its value until the next result.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a reception; accepted only when idle |
| nbits_i | input | 6 | Requested bit count (values above 32 are clamped) |
| key_i | input | 32 | Keystream word used for decryption |
| rx_i | input | 1 | Raw comparator output, asynchronous |
| data_o | output | 32 | Decrypted received word |
| valid_o | output | 1 | One-cycle strobe that marks a new `data_o` |

## Verification
The bench drives windows whose edge counts sit right at the decision thresholds: 20, 21, 59 and 60 edges. A design with an off-by-one comparison would flip one of these bits. A window with 100 edges and a 6-bit counter targets wrap-around: a wrapping counter would read 36 and decode a false 1. Frames of 1 bit, 0 bits and more than 32 bits test the clamp and the empty frame. A restart with a fresh key in the middle of a frame would corrupt both the data and the exact strobe cycle. Mixed patterns of ones and zeros expose a reversed bit order or a key applied to the wrong positions.

// File: rtl/subcar_demod_pkg.sv
package subcar_demod_pkg;

    localparam int DATA_W   = 32;
    localparam int MAX_BITS = 32;
    localparam int IDX_W    = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RX   = 2'd2
    } phase_t;

    typedef struct packed {
        logic [DATA_W-1:0] key;
        logic [IDX_W-1:0]  nbits;
    } frame_cfg_t;

    function automatic logic [IDX_W-1:0] clamp_bits(input logic [IDX_W-1:0] n);
        if (n > IDX_W'(MAX_BITS))
            return IDX_W'(MAX_BITS);
        return n;
    endfunction

    function automatic logic in_band(input int cnt, input int lo, input int hi);
        return (cnt > lo) && (cnt < hi);
    endfunction

endpackage

// File: rtl/subcar_sync_edge.sv
module subcar_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic edge_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= raw_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_o = s2 ^ s3;
endmodule

// File: rtl/subcar_win_timer.sv
module subcar_win_timer #(
    parameter int WAIT_CYC = 7920,
    parameter int WIN_CYC  = 2400
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic sel_win_i,
    output logic hit_o
);
    localparam int MAX_CYC = (WAIT_CYC > WIN_CYC) ? WAIT_CYC : WIN_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC) + 1;

    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] limit;

    assign limit = sel_win_i ? TMR_W'(WIN_CYC - 1) : TMR_W'(WAIT_CYC - 1);
    assign hit_o = run_i && (tmr == limit);

    always_ff @(posedge clk) begin
        if (rst)
            tmr <= '0;
        else if (!run_i || hit_o)
            tmr <= '0;
        else
            tmr <= tmr + TMR_W'(1);
    end
endmodule

// File: rtl/subcar_edge_cnt.sv
module subcar_edge_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             clear_i,
    input  logic             edge_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] total_o
);
    always_comb begin
        if (cnt_o == {CNT_W{1'b1}})
            total_o = cnt_o;
        else
            total_o = cnt_o + CNT_W'(edge_i);
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i || clear_i)
            cnt_o <= '0;
        else
            cnt_o <= total_o;
    end
endmodule

// File: rtl/subcar_demod.sv
module subcar_demod
    import subcar_demod_pkg::*;
#(
    parameter int WAIT_CYC = 7920,
    parameter int WIN_CYC  = 2400,
    parameter int CNT_W    = 8,
    parameter int ONE_LO   = 20,
    parameter int ONE_HI   = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [5:0]        nbits_i,
    input  logic [31:0]       key_i,
    input  logic              rx_i,
    output logic [31:0]       data_o,
    output logic              valid_o
);
    phase_t            state;
    frame_cfg_t        cfg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rxw_q;
    logic [DATA_W-1:0] rxw_next;
    logic              edge_w;
    logic              win_hit;
    logic              bit_val;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_total;
    logic              in_rx;
    logic              run;

    assign in_rx = (state == ST_RX);
    assign run   = (state != ST_IDLE);

    subcar_sync_edge u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (rx_i),
        .edge_o (edge_w)
    );

    subcar_win_timer #(
        .WAIT_CYC (WAIT_CYC),
        .WIN_CYC  (WIN_CYC)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .sel_win_i (in_rx),
        .hit_o     (win_hit)
    );

    subcar_edge_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en_i    (in_rx),
        .clear_i (win_hit),
        .edge_i  (edge_w),
        .cnt_o   (cnt_q),
        .total_o (cnt_total)
    );

    always_comb begin
        bit_val  = in_band(int'(cnt_total), ONE_LO, ONE_HI);
        rxw_next = rxw_q | (DATA_W'(bit_val) << idx_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            rxw_q   <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q.key   <= key_i;
                        cfg_q.nbits <= clamp_bits(nbits_i);
                        idx_q       <= '0;
                        rxw_q       <= '0;
                        state       <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (win_hit) begin
                        if (cfg_q.nbits == '0) begin
                            data_o  <= cfg_q.key;
                            valid_o <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (win_hit) begin
                        rxw_q <= rxw_next;
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q + IDX_W'(1) == cfg_q.nbits) begin
                            data_o  <= cfg_q.key ^ rxw_next;
                            valid_o <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/subcar_demod_chk.sv
module subcar_demod_chk
    import subcar_demod_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_o,
    input logic [31:0]       data_o,
    input phase_t            state,
    input logic              win_hit,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [IDX_W-1:0]  idx_q,
    input frame_cfg_t        cfg_q
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_o) |-> valid_o);

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX && $past(state) == ST_RX && !$past(win_hit))
        |-> (cnt_q >= $past(cnt_q)));

    // R8
    bit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.nbits <= IDX_W'(MAX_BITS)) && (idx_q <= IDX_W'(MAX_BITS)));

    // R9
    busy_key_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != ST_IDLE) |-> $stable(cfg_q));
endmodule

bind subcar_demod subcar_demod_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_o (valid_o),
    .data_o  (data_o),
    .state   (state),
    .win_hit (win_hit),
    .cnt_q   (cnt_q),
    .idx_q   (idx_q),
    .cfg_q   (cfg_q)
);

// File: tb/subcar_demod_test.sv
module subcar_demod_test;
    localparam int WAIT_CYC = 100;
    localparam int WIN_CYC  = 200;
    localparam int CNT_W    = 6;
    localparam int LEAD     = 30;

    typedef struct {
        logic [31:0] data;
        int          cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [5:0]  nbits_i = '0;
    logic [31:0] key_i = '0;
    logic        rx_i = 1'b0;
    logic [31:0] data_o;
    logic        valid_o;

    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] last_data = '0;
    exp_t        q[$];
    logic        prev_valid = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    subcar_demod #(
        .WAIT_CYC (WAIT_CYC),
        .WIN_CYC  (WIN_CYC),
        .CNT_W    (CNT_W),
        .ONE_LO   (20),
        .ONE_HI   (60)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .nbits_i (nbits_i),
        .key_i   (key_i),
        .rx_i    (rx_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: compares each strobe with the queue head
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_valid) check("R2 strobe width", {31'b0, valid_o}, 32'd0);
            if (valid_o) begin
                if (q.size() == 0) begin
                    check("R2 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " data"}, data_o, e.data);
                    check({e.tag, " R2 latency"}, cyc, e.cyc);
                    last_data = data_o;
                end
            end
            prev_valid = valid_o;
        end
    end

    task automatic send_frame(input int n, input logic [31:0] key, input int edges[32],
                              input bit poke, input string tag);
        int   eff;
        int   c0;
        logic [31:0] exp_d;
        exp_t e;
        eff = (n > 32) ? 32 : n;
        exp_d = key;
        for (int k = 0; k < eff; k++)
            if (edges[k] > 20 && edges[k] < 60) exp_d[k] = ~exp_d[k];
        @(negedge clk);
        // R11: previous result still held
        check("R11 hold", data_o, last_data);
        c0 = cyc;
        start_i = 1'b1;
        nbits_i = 6'(n);
        key_i   = key;
        e.data = exp_d;
        e.cyc  = c0 + 1 + WAIT_CYC + eff * WIN_CYC;
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < eff; k++) begin
            int base;
            int step;
            base = c0 + 1 + WAIT_CYC + k * WIN_CYC;
            if (poke && k == 0) begin
                // R9: restart attempt with other settings mid-frame
                wait_until(base + 10);
                start_i = 1'b1;
                key_i   = ~key;
                nbits_i = 6'd3;
                @(negedge clk);
                start_i = 1'b0;
            end
            step = (edges[k] > 60) ? 1 : 2;
            wait_until(base + LEAD);
            for (int j = 0; j < edges[k]; j++) begin
                rx_i = ~rx_i;
                repeat (step) @(negedge clk);
            end
        end
        wait_until(e.cyc + 3);
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int ed[32];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {31'b0, valid_o}, 32'd0);
        check("R1 data after reset", data_o, 32'd0);

        // R3 R4 R5 R6: threshold corners and saturation, LSB first
        foreach (ed[i]) ed[i] = 0;
        ed[0] = 42; ed[1] = 0; ed[2] = 21; ed[3] = 20;
        ed[4] = 59; ed[5] = 60; ed[6] = 100; ed[7] = 10;
        send_frame(8, 32'h0, ed, 1'b0, "R3 R4 R5 R6 thresholds");

        // R7: keystream XOR with mixed bits
        foreach (ed[i]) ed[i] = 0;
        for (int i = 0; i < 16; i++) ed[i] = (i % 3 == 1) ? 42 : 0;
        send_frame(16, 32'hA5A5_C3C3, ed, 1'b0, "R7 keystream");

        // R8: count above 32 clamps to 32
        foreach (ed[i]) ed[i] = (i % 4 == 0 || i == 31) ? 30 : 0;
        send_frame(40, 32'h1234_5678, ed, 1'b0, "R8 clamp");

        // R10: zero bits
        foreach (ed[i]) ed[i] = 0;
        send_frame(0, 32'hDEAD_BEEF, ed, 1'b0, "R10 empty frame");

        // R9: restart attempt mid-frame is ignored
        foreach (ed[i]) ed[i] = (i % 2 == 0) ? 50 : 5;
        send_frame(12, 32'hFFFF_0000, ed, 1'b1, "R9 busy start");

        // R6: single bit
        foreach (ed[i]) ed[i] = 0;
        ed[0] = 42;
        send_frame(1, 32'h0, ed, 1'b0, "R6 single bit");

        repeat (5) @(negedge clk);
        check("R2 all results seen", 32'(q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule